// File: doc/BRIEF.md
# Two-Byte Pattern Sequence Detector

This block watches an eight-bit input bus for the byte 0xAB followed, at some later point, by the byte 0xCD, and raises a completion flag once both have been seen in that order. The bus is captured into a register on the local clock before any comparison is made. This gives single-clock sampling and removes direct paths from the pins to the comparators. Only the captured value is ever compared against the two patterns.

A software-controlled enable bit, `arm`, allows the search to start. A zero indication from a companion down-counter, `cnt_zero`, cancels the search. Either abort condition (`arm` low or `cnt_zero` high) returns the machine to idle on the next clock from any state and takes priority over a pattern match. The current two-bit state is brought out next to the completion flag.

The states are IDLE (00), SEEK_FIRST (01, waiting for 0xAB), SEEK_SECOND (10, waiting for 0xCD) and DONE (11). The transitions are:
- START: IDLE to SEEK_FIRST.
- FIRST_HIT: SEEK_FIRST to SEEK_SECOND.
- SECOND_HIT: SEEK_SECOND to DONE.
- ABORT: any state to IDLE.
- HOLD: a state stays where it is.

Top module: `bsd_seq_detect`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `state_o` is 2'b00 (IDLE) and `seq_ok` is 0. The sampling register also clears to 0x00.
- R2: In IDLE (2'b00), a clock edge with `arm`=1 and `cnt_zero`=0 moves to SEEK_FIRST (2'b01). With `arm`=0 the machine stays in IDLE.
- R3: Comparisons use only the registered copy of `raw_in`. A byte driven before clock edge k is compared at edge k+1, so its effect on `state_o` appears after edge k+1.
- R4: SEEK_FIRST (2'b01) stays put while the sampled byte is not 0xAB. When it equals 0xAB, the machine moves to SEEK_SECOND (2'b10).
- R5: SEEK_SECOND (2'b10) stays put while the sampled byte is not 0xCD, including when it is 0xAB again. When it equals 0xCD, the machine moves to DONE (2'b11).
- R6: `seq_ok` is 1 exactly when `state_o` is 2'b11 (DONE).
- R7: DONE stays put whatever the sampled byte is, as long as no abort condition is present.
- R8: `cnt_zero`=1 at a clock edge sends the machine to IDLE from any state. This takes priority over a pattern match.
- R9: `arm`=0 at a clock edge sends the machine to IDLE from any state. This takes priority over a pattern match.
- R10: In IDLE, `arm`=1 together with `cnt_zero`=1 keeps the machine in IDLE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local sampling and state clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Software enable bit for the search; cleared by reset upstream |
| cnt_zero | input | 1 | Zero indication from the companion down-counter; aborts the search |
| raw_in | input | 8 | External input bus, sampled before comparison |
| seq_ok | output | 1 | High while the full two-byte sequence has been detected |
| state_o | output | 2 | Current state encoding |

## Verification
The hardest situations to reach are an abort that arrives in the same cycle as a matching sampled byte, and a repeat of the first pattern while the machine waits for the second. Both depend on what the sampling register holds, not on the bus value at that edge. The stimulus therefore drives each byte one cycle ahead of the edge where it must match. Abort requests are then placed on the edge where 0xAB or 0xCD sits in the sampling register. A reference model in the bench tracks both the sampling register and the state, so every cycle's expected state accounts for the one-cycle capture delay.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE        = 2'b00,
        ST_SEEK_FIRST  = 2'b01,
        ST_SEEK_SECOND = 2'b10,
        ST_DONE        = 2'b11
    } bsd_state_e;
endpackage

// File: rtl/bsd_sampler.sv
module bsd_sampler #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= din;
            end
        end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/bsd_match.sv
module bsd_match #(
    parameter int               WIDTH   = 8,
    parameter logic [WIDTH-1:0] PATTERN = '0
) (
    input  logic [WIDTH-1:0] sample,
    output logic             hit
);
    assign hit = (sample == PATTERN);
endmodule

// File: rtl/bsd_fsm.sv
module bsd_fsm
    import bsd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic       cnt_zero,
    input  logic       hit_first,
    input  logic       hit_second,
    output bsd_state_e state,
    output logic       done
);
    bsd_state_e state_q, state_d;
    logic       abort;

    assign abort = cnt_zero || !arm;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (!abort)          state_d = ST_SEEK_FIRST;
            ST_SEEK_FIRST:  if (abort)           state_d = ST_IDLE;
                            else if (hit_first)  state_d = ST_SEEK_SECOND;
            ST_SEEK_SECOND: if (abort)           state_d = ST_IDLE;
                            else if (hit_second) state_d = ST_DONE;
            ST_DONE:        if (abort)           state_d = ST_IDLE;
            default:                             state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state = state_q;
        done  = 1'b0;
        unique case (state_q)
            ST_DONE: done = 1'b1;
            default: done = 1'b0;
        endcase
    end
endmodule

// File: rtl/bsd_seq_detect.sv
module bsd_seq_detect #(
    parameter int               WIDTH        = 8,
    parameter int               SAMPLE_DEPTH = 1,
    parameter logic [WIDTH-1:0] FIRST_BYTE   = 8'hAB,
    parameter logic [WIDTH-1:0] SECOND_BYTE  = 8'hCD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             cnt_zero,
    input  logic [WIDTH-1:0] raw_in,
    output logic             seq_ok,
    output logic [1:0]       state_o
);
    import bsd_pkg::*;

    logic [WIDTH-1:0] sampled;
    logic             hit_first, hit_second;
    bsd_state_e       cur_state;

    bsd_sampler #(.WIDTH(WIDTH), .DEPTH(SAMPLE_DEPTH)) u_sampler (
        .clk(clk), .rst_n(rst_n), .din(raw_in), .dout(sampled)
    );

    bsd_match #(.WIDTH(WIDTH), .PATTERN(FIRST_BYTE)) u_match_first (
        .sample(sampled), .hit(hit_first)
    );

    bsd_match #(.WIDTH(WIDTH), .PATTERN(SECOND_BYTE)) u_match_second (
        .sample(sampled), .hit(hit_second)
    );

    bsd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .arm(arm), .cnt_zero(cnt_zero),
        .hit_first(hit_first), .hit_second(hit_second),
        .state(cur_state), .done(seq_ok)
    );

    assign state_o = cur_state;
endmodule

// File: rtl/bsd_seq_detect_chk.sv
module bsd_seq_detect_chk #(
    parameter int               WIDTH       = 8,
    parameter logic [WIDTH-1:0] SECOND_BYTE = 8'hCD
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm,
    input logic             cnt_zero,
    input logic [WIDTH-1:0] sampled,
    input logic             seq_ok,
    input logic [1:0]       state_o
);
    p_ok_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_ok == (state_o == 2'b11));

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b00 && arm && !cnt_zero) |=> state_o == 2'b01);

    p_seek_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b01) |=> state_o != 2'b11);

    p_seek_second_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b10 && arm && !cnt_zero && sampled != SECOND_BYTE)
        |=> state_o == 2'b10);

    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b11 && arm && !cnt_zero) |=> state_o == 2'b11);

    p_abort_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_zero |=> state_o == 2'b00);

    p_abort_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> state_o == 2'b00);
endmodule

bind bsd_seq_detect bsd_seq_detect_chk #(
    .WIDTH(WIDTH), .SECOND_BYTE(SECOND_BYTE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .arm(arm), .cnt_zero(cnt_zero),
    .sampled(sampled), .seq_ok(seq_ok), .state_o(state_o)
);

// File: tb/bsd_seq_detect_tb.sv
module bsd_seq_detect_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [1:0] st;
        logic       ok;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arm = 1'b0;
    logic       cnt_zero = 1'b0;
    logic [7:0] raw_in = 8'h00;
    logic       seq_ok;
    logic [1:0] state_o;

    int   checks = 0;
    int   failures = 0;
    bit   finished = 1'b0;
    exp_t exp_q[$];

    logic [7:0] m_samp;
    logic [1:0] m_state;

    always #(CLK_PERIOD/2) clk = ~clk;

    bsd_seq_detect dut_i (
        .clk(clk), .rst_n(rst_n), .arm(arm), .cnt_zero(cnt_zero),
        .raw_in(raw_in), .seq_ok(seq_ok), .state_o(state_o)
    );

    task automatic check(input string tag, input logic [1:0] st, input logic ok);
        checks++;
        if (state_o !== st || seq_ok !== ok) begin
            failures++;
            $display("FAIL %s: state=%b seq_ok=%b expected state=%b seq_ok=%b",
                     tag, state_o, seq_ok, st, ok);
        end
    endtask

    task automatic step(input logic a, input logic z, input logic [7:0] d, input string tag);
        logic [1:0] nxt;
        exp_t e;
        @(negedge clk);
        arm = a; cnt_zero = z; raw_in = d;
        nxt = m_state;
        if (z || !a) nxt = 2'b00;
        else begin
            case (m_state)
                2'b00: nxt = 2'b01;
                2'b01: if (m_samp == 8'hAB) nxt = 2'b10;
                2'b10: if (m_samp == 8'hCD) nxt = 2'b11;
                default: nxt = 2'b11;
            endcase
        end
        m_samp  = d;
        m_state = nxt;
        e.st = nxt; e.ok = (nxt == 2'b11); e.tag = tag;
        exp_q.push_back(e);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, e.st, e.ok);
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : driver
        logic [7:0] lfsr;
        m_samp = 8'h00; m_state = 2'b00;
        repeat (3) @(negedge clk);
        check("R1 during reset", 2'b00, 1'b0);
        rst_n = 1'b1;
        // R1: first edge after release with arm low stays idle
        step(1'b0, 1'b0, 8'hAB, "R1");
        step(1'b0, 1'b0, 8'hAB, "R2 arm low stays idle");
        step(1'b1, 1'b1, 8'h00, "R10 arm and zero stays idle");
        step(1'b1, 1'b0, 8'h00, "R2 start");
        step(1'b1, 1'b0, 8'hAB, "R3 byte not yet sampled");
        step(1'b1, 1'b0, 8'h12, "R4 first hit");
        step(1'b1, 1'b0, 8'hAB, "R5 hold on other byte");
        step(1'b1, 1'b0, 8'hCD, "R5 hold on repeated first byte");
        step(1'b1, 1'b0, 8'h55, "R6 second hit done");
        step(1'b1, 1'b0, 8'h00, "R7 done holds");
        step(1'b1, 1'b0, 8'hAB, "R7 done holds");
        step(1'b1, 1'b1, 8'h00, "R8 zero aborts done");
        // zero beats a second-byte match
        step(1'b1, 1'b0, 8'hAB, "R2 restart");
        step(1'b1, 1'b0, 8'hCD, "R4 first hit");
        step(1'b1, 1'b1, 8'h00, "R8 zero beats match");
        // arm low beats a first-byte match
        step(1'b1, 1'b0, 8'hAB, "R2 restart");
        step(1'b0, 1'b0, 8'h00, "R9 arm low beats match");
        // reach done, then drop arm
        step(1'b1, 1'b0, 8'hAB, "R2 restart");
        step(1'b1, 1'b0, 8'hCD, "R4 first hit");
        step(1'b1, 1'b0, 8'h00, "R6 done");
        step(1'b0, 1'b0, 8'h00, "R9 arm low aborts done");
        // mixed traffic
        lfsr = 8'h5A;
        for (int i = 0; i < 60; i++) begin
            logic [7:0] d;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            d = (lfsr[1:0] == 2'b00) ? 8'hAB : (lfsr[1:0] == 2'b01) ? 8'hCD : lfsr;
            step(lfsr[7:3] != 5'd0, lfsr[6:2] == 5'd31, d, "R4 mixed traffic");
        end
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule